// File: doc/BRIEF.md
# Mixed-Width Register Access Adapter

This block connects a bus master that issues byte, halfword or word accesses to a register file whose registers each have their own fixed width of one, two or four bytes. A per-slot width table, one entry for every four-byte slot of the register window, tells the adapter how wide the register behind each slot is. The adapter turns every master access into one or more native accesses of exactly that width, so the register file only ever sees accesses of its own size.

A master access wider than the native register is split into native-sized pieces, issued one per cycle at ascending addresses. Data is big-endian: the lowest address holds the most significant piece. A master read narrower than the native register reads the whole containing register and returns the addressed byte lanes. A narrower write becomes a read of the containing register followed by a write of the merged value. The master sees `busy` while native accesses are in progress and a one-cycle `done` pulse with the read data when the transfer is over.

Top module: `mixed_width_adapter`

## Requirements
- R1: Only the low 10 bits of the master address are used; an address that differs only in bits above bit 9 reaches the same register.
- R2: A request whose 10-bit offset is 0x200 or above, or whose size code is 3, makes no native access; `done` rises in the cycle after the request edge and returns read data 0.
- R3: Native accesses use the width of the slot (offset bits 9:2) from the width table, whose codes are 0 = unimplemented, 1 = byte, 2 = halfword, 3 = word; an unimplemented slot is accessed as bytes. `nat_size` is 0 for a byte, 1 for a halfword, 2 for a word. Default table: slots 0-15 byte, 16-31 halfword, 32-47 word, 48-63 unimplemented, 64-127 byte.
- R4: Master size codes are 0 = byte, 1 = halfword, 2 = word; address bits below the access size are ignored, so every access is naturally aligned.
- R5: A read wider than the native width becomes native reads at ascending addresses; the piece from the lowest address forms the most significant part of `rdata`.
- R6: A write wider than the native width becomes native writes at ascending addresses, the most significant part of `wdata` going to the lowest address.
- R7: A read narrower than the native width makes one native read of the containing register and returns the addressed lanes right-aligned, the lowest address being the most significant lane.
- R8: A write narrower than the native width reads the containing register, then writes it back with only the addressed lanes replaced; the write cycle directly follows the read.
- R9: Exactly one native access is made per cycle while `busy` is high; for a transfer of k native accesses, `done` is high in the k-th cycle after the request edge (the first cycle when k is 0), `busy` is low whenever `done` is high, and `rdata` is 0 after a write.
- R10: A request raised while `busy` is high is ignored and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Master request, taken when `busy` is low |
| we | input | 1 | 1 = write, 0 = read |
| size | input | 2 | Access size code (0 byte, 1 halfword, 2 word, 3 reserved) |
| addr | input | ADDR_W | Master byte address |
| wdata | input | 32 | Write data, right-aligned |
| busy | output | 1 | Native accesses in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read data, right-aligned, valid with `done` |
| nat_req | output | 1 | Native access strobe |
| nat_we | output | 1 | Native write |
| nat_size | output | 2 | Native access size (0 byte, 1 halfword, 2 word) |
| nat_addr | output | OFS_W | Native byte offset |
| nat_wdata | output | 32 | Native write data, right-aligned |
| nat_rdata | input | 32 | Native read data, same-cycle, right-aligned |

## Verification
A wrong beat count or a stale beat index shows at once on the native port as an access at the wrong offset or size, and at the master side as `done` arriving a cycle early or late; the bench counts cycles and native strobes per transfer. A bad lane shift or merge mask leaves either wrong `rdata` in the `done` cycle or a corrupted neighbour byte in the bench's register model, which a later read-back and a final sweep of the whole model expose. Swapped piece order in a split shows as byte-reversed data on the first read-back of a written value.

// File: rtl/mwa_pkg.sv
`timescale 1ns/1ps
package mwa_pkg;

   localparam int MWA_MAX_SLOTS = 256;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } mwa_state_e;

   // Width codes: 0 unimplemented, 1 byte, 2 halfword, 3 word.
   function automatic logic [2*MWA_MAX_SLOTS-1:0] mwa_default_map();
      logic [2*MWA_MAX_SLOTS-1:0] m;
      m = '0;
      for (int s = 0; s < MWA_MAX_SLOTS; s++) begin
         if (s < 16)      m[2*s +: 2] = 2'd1;
         else if (s < 32) m[2*s +: 2] = 2'd2;
         else if (s < 48) m[2*s +: 2] = 2'd3;
         else if (s < 64) m[2*s +: 2] = 2'd0;
         else             m[2*s +: 2] = 2'd1;
      end
      return m;
   endfunction

endpackage

// File: rtl/mwa_width_lut.sv
`timescale 1ns/1ps
module mwa_width_lut
   import mwa_pkg::*;
#(
   parameter int SLOTS = 128,
   parameter logic [2*MWA_MAX_SLOTS-1:0] MAP = '0,
   localparam int SW = $clog2(SLOTS)
) (
   input  logic [SW-1:0] slot,
   output logic [1:0]    code
);
   logic [1:0] tbl [SLOTS];

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      assign tbl[g] = MAP[2*g +: 2];
   end

   assign code = tbl[slot];
endmodule

// File: rtl/mwa_planner.sv
`timescale 1ns/1ps
module mwa_planner #(
   parameter int OFS_W = 10
) (
   input  logic [OFS_W-1:0] ofs,
   input  logic [1:0]       size,
   input  logic             we,
   input  logic [1:0]       code,
   input  logic             in_range,
   output logic [1:0]       al,
   output logic [1:0]       nl,
   output logic [2:0]       beats,
   output logic             reject,
   output logic [OFS_W-1:0] base
);
   assign al     = size;
   assign nl     = (code == 2'd0) ? 2'd0 : code - 2'd1;
   assign reject = !in_range || (size == 2'd3);

   always_comb begin
      case (al)
         2'd0:    base = ofs;
         2'd1:    base = {ofs[OFS_W-1:1], 1'b0};
         default: base = {ofs[OFS_W-1:2], 2'b00};
      endcase
   end

   always_comb begin
      if (al > nl)             beats = ((al - nl) == 2'd2) ? 3'd4 : 3'd2;
      else if (we && (al < nl)) beats = 3'd2;
      else                      beats = 3'd1;
   end
endmodule

// File: rtl/mwa_lane_merge.sv
`timescale 1ns/1ps
module mwa_lane_merge #(
   parameter int DW = 32
) (
   input  logic [1:0]    al,
   input  logic [1:0]    nl,
   input  logic [1:0]    sub,
   input  logic [1:0]    beat,
   input  logic [2:0]    beats,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] rdv,
   input  logic [DW-1:0] acc,
   output logic [DW-1:0] nat_wdata,
   output logic [DW-1:0] acc_next,
   output logic [DW-1:0] rd_final
);
   function automatic logic [DW-1:0] lmask(input logic [1:0] l);
      case (l)
         2'd0:    return DW'(8'hFF);
         2'd1:    return DW'(16'hFFFF);
         default: return '1;
      endcase
   endfunction

   logic [5:0]    nbits, sh;
   logic [2:0]    nbytes, abytes, lanes, left;
   logic [6:0]    psh;
   logic [DW-1:0] rd_n, ext, merged, wpiece;

   assign nbits  = 6'd8 << nl;
   assign nbytes = 3'd1 << nl;
   assign abytes = 3'd1 << al;
   assign lanes  = nbytes - abytes - {1'b0, sub};
   assign sh     = {lanes, 3'b000};
   assign left   = beats - 3'd1 - {1'b0, beat};
   assign psh    = (nl == 2'd0) ? {1'b0, left, 3'b000} : {left, 4'b0000};

   assign rd_n     = rdv & lmask(nl);
   assign acc_next = (nl == 2'd2) ? rd_n : ((acc << nbits) | rd_n);
   assign ext      = (rd_n >> sh) & lmask(al);
   assign rd_final = (al > nl) ? acc_next : ext;

   assign wpiece = (wdata >> psh) & lmask(nl);
   assign merged = ((acc & ~(lmask(al) << sh)) | ((wdata & lmask(al)) << sh)) & lmask(nl);

   assign nat_wdata = (al < nl) ? merged : wpiece;
endmodule

// File: rtl/mixed_width_adapter.sv
`timescale 1ns/1ps
module mixed_width_adapter
   import mwa_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int OFS_W  = 10,
   parameter int SLOTS  = 128,
   parameter int DW     = 32,
   parameter logic [2*MWA_MAX_SLOTS-1:0] WIDTH_MAP = mwa_default_map()
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              we,
   input  logic [1:0]        size,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DW-1:0]     wdata,
   output logic              busy,
   output logic              done,
   output logic [DW-1:0]     rdata,
   output logic              nat_req,
   output logic              nat_we,
   output logic [1:0]        nat_size,
   output logic [OFS_W-1:0]  nat_addr,
   output logic [DW-1:0]     nat_wdata,
   input  logic [DW-1:0]     nat_rdata
);
   localparam int LIMIT  = SLOTS * 4;
   localparam int SLOT_W = $clog2(SLOTS);

   if (SLOTS > MWA_MAX_SLOTS || (SLOTS & (SLOTS - 1)) != 0) begin : g_bad_slots
      $error("SLOTS must be a power of two no larger than MWA_MAX_SLOTS");
   end
   if (SLOT_W + 2 > OFS_W || ADDR_W < OFS_W) begin : g_bad_ofs
      $error("OFS_W must cover the slot window and fit in ADDR_W");
   end
   if (DW != 32) begin : g_bad_dw
      $error("DW must be 32");
   end

   // ---------------- request decode ----------------
   logic [OFS_W-1:0] ofs, base;
   logic             in_range, reject;
   logic [1:0]       code, al, nl;
   logic [2:0]       beats;
   logic             unused_addr_hi;

   assign ofs            = addr[OFS_W-1:0];
   assign unused_addr_hi = ^addr;
   assign in_range       = {1'b0, ofs} < (OFS_W+1)'(LIMIT);

   mwa_width_lut #(.SLOTS(SLOTS), .MAP(WIDTH_MAP)) u_lut (
      .slot (ofs[SLOT_W+1:2]),
      .code (code)
   );

   mwa_planner #(.OFS_W(OFS_W)) u_plan (
      .ofs (ofs), .size (size), .we (we), .code (code), .in_range (in_range),
      .al (al), .nl (nl), .beats (beats), .reject (reject), .base (base)
   );

   // ---------------- sequencer state ----------------
   mwa_state_e       state_q;
   logic [OFS_W-1:0] base_q;
   logic [1:0]       al_q, nl_q, beat_q;
   logic [2:0]       beats_q;
   logic             we_q;
   logic [DW-1:0]    wdata_q, acc_q, rdata_q;
   logic [DW-1:0]    acc_next, rd_final;
   logic             accept, last, split_q, rmw_q;
   logic [OFS_W-1:0] nbm, step;

   assign accept  = req && (state_q != ST_RUN);
   assign last    = ({1'b0, beat_q} + 3'd1) == beats_q;
   assign split_q = al_q > nl_q;
   assign rmw_q   = we_q && (al_q < nl_q);
   assign nbm     = (OFS_W'(1) << nl_q) - OFS_W'(1);
   assign step    = OFS_W'(beat_q) << nl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         base_q  <= '0;
         al_q    <= '0;
         nl_q    <= '0;
         beat_q  <= '0;
         beats_q <= '0;
         we_q    <= 1'b0;
         wdata_q <= '0;
         acc_q   <= '0;
         rdata_q <= '0;
      end else if (state_q == ST_RUN) begin
         acc_q  <= acc_next;
         beat_q <= beat_q + 2'd1;
         if (last) begin
            state_q <= ST_FIN;
            rdata_q <= we_q ? '0 : rd_final;
         end
      end else if (accept) begin
         base_q  <= base;
         al_q    <= al;
         nl_q    <= nl;
         beats_q <= beats;
         we_q    <= we;
         wdata_q <= wdata;
         beat_q  <= '0;
         acc_q   <= '0;
         if (reject) begin
            state_q <= ST_FIN;
            rdata_q <= '0;
         end else begin
            state_q <= ST_RUN;
         end
      end else begin
         state_q <= ST_IDLE;
      end
   end

   // ---------------- native port ----------------
   mwa_lane_merge #(.DW(DW)) u_lanes (
      .al (al_q), .nl (nl_q), .sub (base_q[1:0] & nbm[1:0]), .beat (beat_q),
      .beats (beats_q), .wdata (wdata_q), .rdv (nat_rdata), .acc (acc_q),
      .nat_wdata (nat_wdata), .acc_next (acc_next), .rd_final (rd_final)
   );

   assign nat_req  = (state_q == ST_RUN);
   assign nat_we   = nat_req && we_q && !(rmw_q && (beat_q == 2'd0));
   assign nat_size = nl_q;
   assign nat_addr = split_q ? (base_q + step) : (base_q & ~nbm);

   assign busy  = (state_q == ST_RUN);
   assign done  = (state_q == ST_FIN);
   assign rdata = rdata_q;

   // ---------------- assertions ----------------
   a_r2_native_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      nat_req |-> ({1'b0, nat_addr} < (OFS_W+1)'(LIMIT)));

   a_r3_native_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      nat_req |-> ((nat_size == 2'd0) ||
                   (nat_size == 2'd1 && !nat_addr[0]) ||
                   (nat_size == 2'd2 && nat_addr[1:0] == 2'b00)));

   a_r5_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      (nat_req && beat_q != 2'd0) |-> (nat_addr >= $past(nat_addr)));

   a_r8_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
      (nat_req && nat_we && (al_q < nl_q)) |-> ($past(nat_req) && !$past(nat_we)));

   a_r9_busy_ends_in_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
endmodule

// File: tb/tb_mixed_width_adapter.sv
`timescale 1ns/1ps
module tb_mixed_width_adapter;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        req, we;
   logic [1:0]  size;
   logic [15:0] addr;
   logic [31:0] wdata;
   logic        busy, done;
   logic [31:0] rdata;
   logic        nat_req, nat_we;
   logic [1:0]  nat_size;
   logic [9:0]  nat_addr;
   logic [31:0] nat_wdata, nat_rdata;

   always #5 clk = ~clk;

   mixed_width_adapter dut (
      .clk, .rst_n, .req, .we, .size, .addr, .wdata, .busy, .done, .rdata,
      .nat_req, .nat_we, .nat_size, .nat_addr, .nat_wdata, .nat_rdata
   );

   int tests = 0;
   int fails = 0;
   int mon_fail = 0;
   int nacc = 0;

   // expected native size per slot (R3 default table; unimplemented -> byte)
   function automatic logic [1:0] exp_nl(input int a);
      int s = a / 4;
      if (s < 16) return 2'd0;
      if (s < 32) return 2'd1;
      if (s < 48) return 2'd2;
      return 2'd0;
   endfunction

   // ---------------- native register model ----------------
   logic [7:0] mem [512];
   logic       prev_v;
   logic [9:0] prev_a;

   always_comb begin
      int ia;
      ia = int'(nat_addr[8:0]);
      case (nat_size)
         2'd0:    nat_rdata = {24'h0, mem[ia]};
         2'd1:    nat_rdata = {16'h0, mem[ia], mem[(ia+1)%512]};
         default: nat_rdata = {mem[ia], mem[(ia+1)%512], mem[(ia+2)%512], mem[(ia+3)%512]};
      endcase
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 512; i++) mem[i] <= 8'(i * 37 + 11);
         prev_v <= 1'b0;
         prev_a <= '0;
      end else begin
         prev_v <= nat_req;
         prev_a <= nat_addr;
         if (nat_req) begin
            nacc <= nacc + 1;
            if (nat_size != exp_nl(int'(nat_addr))) begin
               mon_fail <= mon_fail + 1;
               $display("FAIL R3 native size at %0h: actual %0d expected %0d",
                        nat_addr, nat_size, exp_nl(int'(nat_addr)));
            end
            if (prev_v && nat_addr < prev_a) begin
               mon_fail <= mon_fail + 1;
               $display("FAIL R5 native order: actual %0h expected >= %0h", nat_addr, prev_a);
            end
            if (nat_we) begin
               case (nat_size)
                  2'd0: mem[nat_addr[8:0]] <= nat_wdata[7:0];
                  2'd1: begin
                     mem[nat_addr[8:0]]      <= nat_wdata[15:8];
                     mem[nat_addr[8:0] + 1]  <= nat_wdata[7:0];
                  end
                  default: begin
                     mem[nat_addr[8:0]]     <= nat_wdata[31:24];
                     mem[nat_addr[8:0] + 1] <= nat_wdata[23:16];
                     mem[nat_addr[8:0] + 2] <= nat_wdata[15:8];
                     mem[nat_addr[8:0] + 3] <= nat_wdata[7:0];
                  end
               endcase
            end
         end
      end
   end

   // ---------------- expected model ----------------
   logic [7:0] refm [512];

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   // {req tag[3:0], we, size[1:0], addr[15:0], wdata[31:0], native accesses[2:0]}
   localparam int NV = 30;
   localparam logic [57:0] VEC [NV] = '{
      {4'd5,  1'b0, 2'd2, 16'h0000, 32'h0,        3'd4}, // R5 word from byte slots
      {4'd3,  1'b0, 2'd1, 16'h0042, 32'h0,        3'd1}, // R3 half native
      {4'd3,  1'b0, 2'd2, 16'h0080, 32'h0,        3'd1}, // R3 word native
      {4'd7,  1'b0, 2'd0, 16'h0083, 32'h0,        3'd1}, // R7 byte of word
      {4'd7,  1'b0, 2'd1, 16'h0086, 32'h0,        3'd1}, // R7 low half of word
      {4'd7,  1'b0, 2'd0, 16'h0041, 32'h0,        3'd1}, // R7 odd byte of half
      {4'd5,  1'b0, 2'd2, 16'h0044, 32'h0,        3'd2}, // R5 word from halves
      {4'd6,  1'b1, 2'd2, 16'h0010, 32'hA1B2C3D4, 3'd4}, // R6 word into bytes
      {4'd6,  1'b0, 2'd2, 16'h0010, 32'h0,        3'd4},
      {4'd8,  1'b1, 2'd0, 16'h0045, 32'h0000005A, 3'd2}, // R8 byte into half
      {4'd8,  1'b0, 2'd1, 16'h0044, 32'h0,        3'd1},
      {4'd8,  1'b1, 2'd1, 16'h008A, 32'h0000BEEF, 3'd2}, // R8 half into word
      {4'd8,  1'b0, 2'd2, 16'h0088, 32'h0,        3'd1},
      {4'd6,  1'b1, 2'd2, 16'h0048, 32'h11223344, 3'd2}, // R6 word into halves
      {4'd6,  1'b0, 2'd2, 16'h0048, 32'h0,        3'd2},
      {4'd3,  1'b0, 2'd1, 16'h00C2, 32'h0,        3'd2}, // R3 unimplemented slot
      {4'd3,  1'b1, 2'd1, 16'h00C4, 32'h00001234, 3'd2},
      {4'd3,  1'b0, 2'd1, 16'h00C4, 32'h0,        3'd2},
      {4'd2,  1'b0, 2'd2, 16'h0204, 32'h0,        3'd0}, // R2 out of window
      {4'd2,  1'b1, 2'd2, 16'h0200, 32'hFFFFFFFF, 3'd0},
      {4'd1,  1'b0, 2'd2, 16'h1010, 32'h0,        3'd4}, // R1 alias of 0x010
      {4'd2,  1'b0, 2'd3, 16'h0000, 32'h0,        3'd0}, // R2 reserved size
      {4'd4,  1'b0, 2'd2, 16'h0013, 32'h0,        3'd4}, // R4 misaligned word
      {4'd4,  1'b1, 2'd1, 16'h0047, 32'h0000CAFE, 3'd1},
      {4'd4,  1'b0, 2'd1, 16'h0047, 32'h0,        3'd1},
      {4'd8,  1'b1, 2'd0, 16'h0082, 32'h00000077, 3'd2}, // R8 byte into word
      {4'd7,  1'b0, 2'd2, 16'h0080, 32'h0,        3'd1},
      {4'd1,  1'b1, 2'd0, 16'h3181, 32'h0000009C, 3'd1}, // R1 high bits ignored
      {4'd1,  1'b0, 2'd0, 16'h0181, 32'h0,        3'd1},
      {4'd2,  1'b0, 2'd0, 16'h03FF, 32'h0,        3'd0}
   };

   task automatic xfer(input logic [57:0] v);
      string       rq;
      logic        vwe;
      logic [1:0]  vsz;
      logic [15:0] vad;
      logic [31:0] vwd, exp;
      int          k, ofs, ab, base, cyc, n0;
      bit          valid;
      rq  = $sformatf("R%0d", v[57:54]);
      vwe = v[53]; vsz = v[52:51]; vad = v[50:35]; vwd = v[34:3]; k = int'(v[2:0]);
      ofs   = int'(vad[9:0]);
      valid = (ofs < 512) && (vsz != 2'd3);
      ab    = 1 << vsz;
      base  = valid ? (ofs & ~(ab - 1)) : 0;
      exp   = '0;
      if (valid && !vwe) for (int i = 0; i < ab; i++) exp = (exp << 8) | 32'(refm[base + i]);
      @(negedge clk);
      req = 1'b1; we = vwe; size = vsz; addr = vad; wdata = vwd;
      n0 = nacc;
      @(negedge clk);
      req = 1'b0;
      cyc = 0;
      while (!done && cyc < 20) begin
         @(negedge clk);
         cyc++;
      end
      chk(cyc == k, rq, $sformatf("done latency @%0h", vad), 32'(cyc), 32'(k));
      chk((nacc - n0) == k, rq, $sformatf("native accesses @%0h", vad), 32'(nacc - n0), 32'(k));
      chk(rdata == exp, rq, $sformatf("rdata @%0h", vad), rdata, exp);
      if (valid && vwe) for (int i = 0; i < ab; i++) refm[base + i] = 8'(vwd >> (8 * (ab - 1 - i)));
   endtask

   initial begin
      int n0, cyc;
      for (int i = 0; i < 512; i++) refm[i] = 8'(i * 37 + 11);
      rst_n = 1'b0; req = 1'b0; we = 1'b0; size = '0; addr = '0; wdata = '0;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk(!busy && !done && !nat_req, "R9", "reset handshake", {29'h0, busy, done, nat_req}, 32'h0);
      chk(rdata == 32'h0, "R9", "reset rdata", rdata, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int j = 0; j < NV; j++) xfer(VEC[j]);

      // R10: request while busy is ignored
      @(negedge clk);
      req = 1'b1; we = 1'b1; size = 2'd2; addr = 16'h0020; wdata = 32'h01020304;
      n0 = nacc;
      @(negedge clk);
      chk(busy == 1'b1, "R9", "busy during split", {31'h0, busy}, 32'h1);
      req = 1'b1; we = 1'b1; size = 2'd2; addr = 16'h0084; wdata = 32'hDEADBEEF;
      @(negedge clk);
      req = 1'b0;
      cyc = 1;
      while (!done && cyc < 20) begin
         @(negedge clk);
         cyc++;
      end
      chk(cyc == 4, "R10", "latency with stray request", 32'(cyc), 32'd4);
      chk((nacc - n0) == 4, "R10", "native accesses with stray request", 32'(nacc - n0), 32'd4);
      for (int i = 0; i < 4; i++) refm[32 + i] = 8'(32'h01020304 >> (8 * (3 - i)));
      xfer({4'd10, 1'b0, 2'd2, 16'h0084, 32'h0, 3'd1});
      xfer({4'd10, 1'b0, 2'd2, 16'h0020, 32'h0, 3'd4});

      // R8: no byte outside the addressed lanes changed anywhere
      @(negedge clk);
      begin
         int bad = 0;
         for (int i = 0; i < 512; i++) if (mem[i] !== refm[i]) bad++;
         chk(bad == 0, "R8", "bytes differing from model", 32'(bad), 32'h0);
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails + mon_fail);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      $display("FAIL R9 watchdog expired: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails + mon_fail + 1);
      $finish;
   end
endmodule